// File: doc/BRIEF.md
# SDH Overhead Serial Drop Ports

This block watches a byte-wide STM-1 stream, one byte per 19.44 MHz clock, together with a marker that flags the first byte of each 125 us frame. It keeps its own row and column count and picks out five kinds of section overhead bytes. Each kind leaves on a dedicated serial output: the two regenerator orderwire bytes, the multiplex orderwire byte, the three-byte regenerator data channel and the nine-byte multiplex data channel.

Each serial output has a gapped clock enable. Each enable is a fixed number of single-cycle pulses spread evenly across the frame: 8 for the orderwire outputs (64 kbit/s), 24 for the regenerator channel (192 kbit/s) and 72 for the multiplex channel (576 kbit/s). Bytes taken from one frame are shifted out, MSB first, during the following frame. An 8 kHz sync pulse marks the first bit of every new orderwire byte. A downstream device samples each data line on the cycle its enable is high. If the frame marker goes missing, the position counter carries on by itself.

Top module: `sdh_ovh_drop`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is low.
- R2: Until the first frame marker arrives, no enable pulses, the data lines and sync stay low, and no byte is captured, so the first frame after the marker shifts out zeros.
- R3: With the frame byte index i counted from 0 at the marker byte and L = 9 x COLS, the orderwire enable is high one cycle after byte i exactly when (i*8 mod L) < 8. That gives 8 pulses per frame, the first on the marker byte.
- R4: The regenerator channel enable follows the same rule with 24 in place of 8, so it gives 24 pulses per frame and covers every orderwire pulse.
- R5: The multiplex channel enable follows the same rule with 72, giving 72 pulses per frame and covering every regenerator channel pulse.
- R6: Rows and columns are counted from 1. The first orderwire output carries the byte at row 2, column 4, the second carries row 2, column 7, and the multiplex orderwire output carries row 9, column 7. Each is taken from the previous frame and sent MSB first, one bit per orderwire pulse.
- R7: The regenerator channel sends, from the previous frame, the bytes at row 3, columns 1, 4 and 7, in that order, each MSB first.
- R8: The multiplex channel sends, from the previous frame, rows 6, 7 and 8, each at columns 1, 4 and 7, in row-major order, each MSB first.
- R9: A data line changes only on a cycle where its enable is high, and holds its bit until the next pulse.
- R10: Sync rises with the first orderwire pulse of a frame and falls with the second, so it is high for exactly one orderwire bit period.
- R11: If no marker arrives after 9 x COLS bytes, the block wraps to a new frame by itself. It then behaves exactly as if the marker had been present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_in | input | 1 | High with the first byte of a frame |
| byte_in | input | 8 | Incoming stream byte |
| ow_bit_en | output | 1 | Orderwire bit enable, 8 per frame |
| ow_sync | output | 1 | Orderwire byte sync, one bit period |
| e1_sd | output | 1 | First regenerator orderwire serial data |
| f1_sd | output | 1 | Second regenerator orderwire serial data |
| e2_sd | output | 1 | Multiplex orderwire serial data |
| rs_bit_en | output | 1 | Regenerator channel bit enable, 24 per frame |
| rs_sd | output | 1 | Regenerator channel serial data |
| ms_bit_en | output | 1 | Multiplex channel bit enable, 72 per frame |
| ms_sd | output | 1 | Multiplex channel serial data |

## Verification
The bench sweeps every byte index of several small frames and predicts each enable from the modulo rule. It checks each data bit against the byte captured one frame earlier.

Several failure modes are targeted:
- An off-by-one in the position counter would drop in a neighbouring byte.
- Reversed bit or byte order would break the MSB-first sequence.
- An enable that slips past the frame boundary would change the per-frame pulse count.
- A flywheel that fails to reload would repeat the stale frame when a marker is left out.
- Capturing before the first marker would make the first serialized frame non-zero.

// File: rtl/sdh_ovh_pkg.sv
package sdh_ovh_pkg;
    localparam int ROWS      = 9;
    localparam int OW_PULSES = 8;
    localparam int RS_PULSES = 24;
    localparam int MS_PULSES = 72;
    localparam int RS_BYTES  = 3;
    localparam int MS_BYTES  = 9;
    // zero-based positions inside the overhead
    localparam int E1_ROW = 1, E1_COL = 3;
    localparam int F1_ROW = 1, F1_COL = 6;
    localparam int E2_ROW = 8, E2_COL = 6;
    localparam int RS_ROW = 2;
    localparam int MS_ROW0 = 5;
    localparam int SLOT_STEP = 3;
endpackage

// File: rtl/sdh_frame_pos.sv
module sdh_frame_pos
    import sdh_ovh_pkg::*;
#(
    parameter int COLS = 270,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_in,
    output logic [RW-1:0] row_c,
    output logic [CW-1:0] col_c,
    output logic          frame_start,
    output logic          run
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          seen;
    } pos_t;

    pos_t s_q, s_d;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.row == RW'(ROWS - 1)) && (s_q.col == CW'(COLS - 1));
        if (fs_in) begin
            s_d.row = '0;
            s_d.col = '0;
        end else if (s_q.col == CW'(COLS - 1)) begin
            s_d.col = '0;
            s_d.row = wrap ? '0 : s_q.row + RW'(1);
        end else begin
            s_d.col = s_q.col + CW'(1);
        end
        run         = fs_in | s_q.seen;
        frame_start = fs_in | (s_q.seen & wrap);
        s_d.seen    = run;
        row_c       = s_d.row;
        col_c       = s_d.col;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sdh_rate_gen.sv
module sdh_rate_gen #(
    parameter int FRAME_LEN = 2430,
    parameter int PULSES    = 8,
    localparam int AW = $clog2(FRAME_LEN + PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic frame_start,
    output logic pulse,
    output logic en_q
);
    typedef struct packed {
        logic [AW-1:0] acc;
        logic          en;
    } rate_t;

    rate_t s_q, s_d;
    logic [AW-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = s_q.acc + AW'(PULSES);
        if (frame_start)              s_d.acc = '0;
        else if (sum >= AW'(FRAME_LEN)) s_d.acc = sum - AW'(FRAME_LEN);
        else                          s_d.acc = sum;
        pulse    = run && (s_d.acc < AW'(PULSES));
        s_d.en   = pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_q = s_q.en;
endmodule

// File: rtl/sdh_ser_chan.sv
module sdh_ser_chan #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic [NBITS-1:0] load_val,
    output logic             sd_q
);
    typedef struct packed {
        logic [NBITS-1:0] shreg;
        logic             sd;
    } chan_t;

    chan_t s_q, s_d;
    logic [NBITS-1:0] src;

    always_comb begin
        s_d = s_q;
        src = load ? load_val : s_q.shreg;
        if (shift_en) begin
            s_d.sd    = src[NBITS-1];
            s_d.shreg = {src[NBITS-2:0], 1'b0};
        end else begin
            s_d.shreg = src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sd_q = s_q.sd;
endmodule

// File: rtl/sdh_ovh_drop.sv
module sdh_ovh_drop
    import sdh_ovh_pkg::*;
#(
    parameter int COLS = 270
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fs_in,
    input  logic [7:0] byte_in,
    output logic       ow_bit_en,
    output logic       ow_sync,
    output logic       e1_sd,
    output logic       f1_sd,
    output logic       e2_sd,
    output logic       rs_bit_en,
    output logic       rs_sd,
    output logic       ms_bit_en,
    output logic       ms_sd
);
    localparam int FRAME_LEN = ROWS * COLS;
    localparam int RW   = $clog2(ROWS);
    localparam int CW   = $clog2(COLS);
    localparam int RS_W = 8 * RS_BYTES;
    localparam int MS_W = 8 * MS_BYTES;
    localparam int RATE_PULSES [3] = '{OW_PULSES, RS_PULSES, MS_PULSES};

    typedef struct packed {
        logic [7:0]      e1;
        logic [7:0]      f1;
        logic [7:0]      e2;
        logic [RS_W-1:0] rs;
        logic [MS_W-1:0] ms;
        logic            sync;
    } cap_t;

    logic [RW-1:0] row_c;
    logic [CW-1:0] col_c;
    logic          frame_start, run;
    logic [2:0]    pulse, en_q;
    cap_t          s_q, s_d;

    sdh_frame_pos #(.COLS(COLS)) u_pos (
        .clk(clk), .rst_n(rst_n), .fs_in(fs_in),
        .row_c(row_c), .col_c(col_c),
        .frame_start(frame_start), .run(run)
    );

    for (genvar g = 0; g < 3; g++) begin : g_rate
        sdh_rate_gen #(.FRAME_LEN(FRAME_LEN), .PULSES(RATE_PULSES[g])) u_rate (
            .clk(clk), .rst_n(rst_n), .run(run), .frame_start(frame_start),
            .pulse(pulse[g]), .en_q(en_q[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (run) begin
            if (row_c == RW'(E1_ROW) && col_c == CW'(E1_COL)) s_d.e1 = byte_in;
            if (row_c == RW'(F1_ROW) && col_c == CW'(F1_COL)) s_d.f1 = byte_in;
            if (row_c == RW'(E2_ROW) && col_c == CW'(E2_COL)) s_d.e2 = byte_in;
            for (int k = 0; k < RS_BYTES; k++) begin
                if (row_c == RW'(RS_ROW) && col_c == CW'(SLOT_STEP * k))
                    s_d.rs[(RS_BYTES - 1 - k) * 8 +: 8] = byte_in;
            end
            for (int k = 0; k < MS_BYTES; k++) begin
                if (row_c == RW'(MS_ROW0 + k / 3) && col_c == CW'(SLOT_STEP * (k % 3)))
                    s_d.ms[(MS_BYTES - 1 - k) * 8 +: 8] = byte_in;
            end
        end
        if (frame_start)   s_d.sync = 1'b1;
        else if (pulse[0]) s_d.sync = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [7:0] ow_val [3];
    logic [2:0] ow_sd;
    assign ow_val[0] = s_q.e1;
    assign ow_val[1] = s_q.f1;
    assign ow_val[2] = s_q.e2;

    for (genvar g = 0; g < 3; g++) begin : g_ow
        sdh_ser_chan #(.NBITS(8)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(frame_start), .shift_en(pulse[0]),
            .load_val(ow_val[g]), .sd_q(ow_sd[g])
        );
    end

    sdh_ser_chan #(.NBITS(RS_W)) u_rs (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .shift_en(pulse[1]),
        .load_val(s_q.rs), .sd_q(rs_sd)
    );

    sdh_ser_chan #(.NBITS(MS_W)) u_ms (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .shift_en(pulse[2]),
        .load_val(s_q.ms), .sd_q(ms_sd)
    );

    assign e1_sd     = ow_sd[0];
    assign f1_sd     = ow_sd[1];
    assign e2_sd     = ow_sd[2];
    assign ow_bit_en = en_q[0];
    assign rs_bit_en = en_q[1];
    assign ms_bit_en = en_q[2];
    assign ow_sync   = s_q.sync;
endmodule

// File: rtl/sdh_ovh_drop_chk.sv
module sdh_ovh_drop_chk (
    input logic clk,
    input logic rst_n,
    input logic ow_bit_en,
    input logic ow_sync,
    input logic e1_sd,
    input logic f1_sd,
    input logic e2_sd,
    input logic rs_bit_en,
    input logic rs_sd,
    input logic ms_bit_en,
    input logic ms_sd
);
    // R4
    rs_covers_ow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ow_bit_en |-> rs_bit_en);
    // R5
    ms_covers_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_bit_en |-> ms_bit_en);
    // R9
    ow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ow_bit_en |-> ($stable(e1_sd) && $stable(f1_sd) && $stable(e2_sd)));
    // R9
    rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_bit_en |-> $stable(rs_sd));
    // R9
    ms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_bit_en |-> $stable(ms_sd));
    // R10
    sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ow_sync) |-> ow_bit_en);
    // R10
    sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ow_bit_en && $past(ow_sync)) |-> !ow_sync);
endmodule

bind sdh_ovh_drop sdh_ovh_drop_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ow_bit_en(ow_bit_en), .ow_sync(ow_sync),
    .e1_sd(e1_sd), .f1_sd(f1_sd), .e2_sd(e2_sd),
    .rs_bit_en(rs_bit_en), .rs_sd(rs_sd),
    .ms_bit_en(ms_bit_en), .ms_sd(ms_sd)
);

// File: tb/sim_sdh_ovh_drop.sv
`timescale 1ns/100ps
module sim_sdh_ovh_drop;
    localparam int COLS = 10;
    localparam int L    = 9 * COLS;
    localparam int NFR  = 8;

    logic clk = 1'b0, rst_n = 1'b0, fs_in = 1'b0;
    logic [7:0] byte_in = '0;
    logic ow_bit_en, ow_sync, e1_sd, f1_sd, e2_sd, rs_bit_en, rs_sd, ms_bit_en, ms_sd;

    sdh_ovh_drop #(.COLS(COLS)) u0 (
        .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .byte_in(byte_in),
        .ow_bit_en(ow_bit_en), .ow_sync(ow_sync), .e1_sd(e1_sd), .f1_sd(f1_sd),
        .e2_sd(e2_sd), .rs_bit_en(rs_bit_en), .rs_sd(rs_sd),
        .ms_bit_en(ms_bit_en), .ms_sd(ms_sd)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int i);
        if (f == 2) return 8'hFF;
        if (f == 5) return (i % 2 == 0) ? 8'hA5 : 8'h5A;
        return 8'(f * 73 + i * 29 + 11);
    endfunction

    task automatic all_low(input string req);
        chk(req, "ow_bit_en", 32'(ow_bit_en), 0);
        chk(req, "ow_sync", 32'(ow_sync), 0);
        chk(req, "e1_sd", 32'(e1_sd), 0);
        chk(req, "f1_sd", 32'(f1_sd), 0);
        chk(req, "e2_sd", 32'(e2_sd), 0);
        chk(req, "rs_bit_en", 32'(rs_bit_en), 0);
        chk(req, "rs_sd", 32'(rs_sd), 0);
        chk(req, "ms_bit_en", 32'(ms_bit_en), 0);
        chk(req, "ms_sd", 32'(ms_sd), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  cur  [L];
        logic [7:0]  prev [L];
        logic [71:0] vec  [5];
        int          nb   [5];
        logic        exp_sd [5];
        logic        exp_sync;
        int          cnt  [3];
        int          seen [3];
        int          kp   [3];
        logic [2:0]  en_obs;
        logic        sd_obs [5];
        kp = '{8, 24, 72};
        nb = '{8, 8, 8, 24, 72};
        foreach (cur[i]) cur[i] = '0;
        foreach (exp_sd[c]) exp_sd[c] = 1'b0;
        exp_sync = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        all_low("R1");
        rst_n = 1'b1;
        @(posedge clk); #1;
        all_low("R1");

        // R2: stream without marker stays idle
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            byte_in = 8'(i * 41 + 3);
            @(posedge clk); #1;
            all_low("R2");
        end

        for (int f = 0; f < NFR; f++) begin
            foreach (prev[i]) prev[i] = cur[i];
            vec[0] = 72'(prev[1 * COLS + 3]);
            vec[1] = 72'(prev[1 * COLS + 6]);
            vec[2] = 72'(prev[8 * COLS + 6]);
            vec[3] = 72'({prev[2 * COLS], prev[2 * COLS + 3], prev[2 * COLS + 6]});
            vec[4] = '0;
            for (int k = 0; k < 9; k++)
                vec[4][71 - 8 * k -: 8] = prev[(5 + k / 3) * COLS + 3 * (k % 3)];
            foreach (cnt[r]) begin cnt[r] = 0; seen[r] = 0; end
            for (int i = 0; i < L; i++) begin
                @(negedge clk);
                // R11: frames 3 and 6 carry no marker
                fs_in   = (i == 0) && (f != 3) && (f != 6);
                byte_in = pat(f, i);
                cur[i]  = byte_in;
                @(posedge clk); #1;
                fs_in = 1'b0;
                for (int r = 0; r < 3; r++) begin
                    en_obs[r] = ((i * kp[r]) % L) < kp[r];
                end
                if (en_obs[0]) begin
                    for (int c = 0; c < 3; c++) exp_sd[c] = vec[c][nb[c] - 1 - cnt[0]];
                    exp_sync = (i == 0);
                    cnt[0]++;
                end
                if (en_obs[1]) begin exp_sd[3] = vec[3][nb[3] - 1 - cnt[1]]; cnt[1]++; end
                if (en_obs[2]) begin exp_sd[4] = vec[4][nb[4] - 1 - cnt[2]]; cnt[2]++; end
                seen[0] += int'(ow_bit_en);
                seen[1] += int'(rs_bit_en);
                seen[2] += int'(ms_bit_en);
                chk((f == 3 || f == 6) ? "R11" : "R3", "ow_bit_en", 32'(ow_bit_en), 32'(en_obs[0]));
                chk("R4", "rs_bit_en", 32'(rs_bit_en), 32'(en_obs[1]));
                chk("R5", "ms_bit_en", 32'(ms_bit_en), 32'(en_obs[2]));
                chk("R10", "ow_sync", 32'(ow_sync), 32'(exp_sync));
                sd_obs = '{e1_sd, f1_sd, e2_sd, rs_sd, ms_sd};
                chk(f == 0 ? "R2" : "R6", "e1_sd", 32'(sd_obs[0]), 32'(exp_sd[0]));
                chk(f == 0 ? "R2" : "R6", "f1_sd", 32'(sd_obs[1]), 32'(exp_sd[1]));
                chk(f == 0 ? "R2" : "R6", "e2_sd", 32'(sd_obs[2]), 32'(exp_sd[2]));
                chk("R7", "rs_sd", 32'(sd_obs[3]), 32'(exp_sd[3]));
                chk("R8", "ms_sd", 32'(sd_obs[4]), 32'(exp_sd[4]));
            end
            chk("R3", "ow pulses per frame", 32'(seen[0]), 32'(8));
            chk("R4", "rs pulses per frame", 32'(seen[1]), 32'(24));
            chk("R5", "ms pulses per frame", 32'(seen[2]), 32'(72));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule